// File: doc/BRIEF.md
# Open-Drain Pin-Pair Control Register

This block is one word-wide control and status register that lets software bit-bang an I2C-style two-wire bus over a clock pin and a data pin. Each pin is open-drain. The line is released high by making the pin an input, so the external pull-up raises it. The line is pulled low by enabling the pin's driver with an output value of 0. A single 32-bit write can change any mix of direction, output value and pull-up disable for either pin. Each of these fields has its own write-enable bit in the same word, so a write touches only the fields it selects.

Reads return the stored fields together with the live pad levels. Each pad input passes through a two-flop synchroniser before it becomes readable. Software samples a line by first making the pin an input and then reading its input bit. Several copies may sit on one register bus, each decoding its own address.

Field layout per pin, relative to the pin's base bit (clock pin base 0, data pin base 8):

| Offset | Field |
|---|---|
| +0 | direction write-enable |
| +1 | direction (1 = output) |
| +2 | value write-enable |
| +3 | output value |
| +4 | synchronised input level (read-only) |
| +5 | pull-up disable write-enable |
| +6 | pull-up disable |

All other bits are reserved and read as 0.

Top module: `odPinPairReg`

## Requirements
- R1: After reset, both pins are inputs (`sclOe`/`sdaOe` = 0), both stored output values are 0, and both pull-ups are enabled (`sclPullEn`/`sdaPullEn` = 1).
- R2: A write to the block's address changes a pin's direction bit (+1) only when the pin's direction write-enable (+0) is 1 in that same write. The stored direction drives the pin's output-enable in the following cycle.
- R3: A pin's output value bit (+3) changes only when its value write-enable (+2) is 1 in that same write. The stored value appears on `sclO`/`sdaO` in the following cycle.
- R4: A write that sets direction to output and value to 0, with both write-enables set, leaves that pin with enable 1 and output 0 in the next cycle. A write of direction 0 with its write-enable set releases the pin (enable 0).
- R5: A pin's pull-up disable bit (+6) changes only when its write-enable (+5) is 1. Any other write leaves it unchanged. The pull-up enable output is the inverse of the stored bit.
- R6: All write-enable bit positions (0, 2, 5, 8, 10, 13) always read as 0.
- R7: While `rdEn` is high and `addr` equals the block's address, `rdData` shows the stored direction, value and pull-up disable bits. It also shows, at +4, each pad level as it was at the clock edge two edges earlier. Otherwise `rdData` is 0.
- R8: A write whose address differs from the block's address changes none of its outputs. Two copies at different addresses are independent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| addr | input | ADDR_W | Register address |
| wrData | input | DATA_W | Write word |
| rdData | output | DATA_W | Read word (combinational, 0 when not addressed) |
| sclIn | input | 1 | Clock pad level |
| sdaIn | input | 1 | Data pad level |
| sclOe | output | 1 | Clock pad driver enable |
| sclO | output | 1 | Clock pad driven value |
| sclPullEn | output | 1 | Clock pad pull-up enable |
| sdaOe | output | 1 | Data pad driver enable |
| sdaO | output | 1 | Data pad driven value |
| sdaPullEn | output | 1 | Data pad pull-up enable |

## Verification
The bench writes words where a field's value differs from its stored contents but its write-enable is clear. A design that ignored the per-field enables would then flip a line or lose a pull-up setting. It also writes to an unrelated address and to the second copy's address. A decoder that was too loose would then disturb the other copy. Pad levels toggle at random against reads, so a synchroniser one stage short or long shows up as a readback that is off by one cycle. Every read also checks that the write-enable positions return 0.

// File: rtl/odpp_pkg.sv
package odpp_pkg;
  localparam int PIN_COUNT     = 2;
  localparam int FIELD_STRIDE  = 8;
  localparam int OFS_DIR_MASK  = 0;
  localparam int OFS_DIR       = 1;
  localparam int OFS_VAL_MASK  = 2;
  localparam int OFS_VAL       = 3;
  localparam int OFS_IN        = 4;
  localparam int OFS_PULL_MASK = 5;
  localparam int OFS_PULL      = 6;

  typedef struct packed {
    logic [PIN_COUNT-1:0] setDir;
    logic [PIN_COUNT-1:0] setVal;
    logic [PIN_COUNT-1:0] setPull;
    logic                 rdSel;
  } strobe_t;
endpackage

// File: rtl/odpp_ctrl.sv
module odpp_ctrl
  import odpp_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h10
) (
  input  logic                 wrEn,
  input  logic                 rdEn,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [PIN_COUNT-1:0] dirMask,
  input  logic [PIN_COUNT-1:0] valMask,
  input  logic [PIN_COUNT-1:0] pullMask,
  output strobe_t              stb
);
  logic hit;
  logic wrHit;

  assign hit   = (addr == BASE_ADDR);
  assign wrHit = wrEn & hit;

  always_comb begin
    stb.setDir  = dirMask  & {PIN_COUNT{wrHit}};
    stb.setVal  = valMask  & {PIN_COUNT{wrHit}};
    stb.setPull = pullMask & {PIN_COUNT{wrHit}};
    stb.rdSel   = rdEn & hit;
  end
endmodule

// File: rtl/odpp_datapath.sv
module odpp_datapath
  import odpp_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              stb,
  input  logic [PIN_COUNT-1:0] dirIn,
  input  logic [PIN_COUNT-1:0] valIn,
  input  logic [PIN_COUNT-1:0] pullIn,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic [PIN_COUNT-1:0] padOe,
  output logic [PIN_COUNT-1:0] padO,
  output logic [PIN_COUNT-1:0] pullEn,
  output logic [DATA_W-1:0]    rdData
);
  logic [PIN_COUNT-1:0]   dirQ;
  logic [PIN_COUNT-1:0]   valQ;
  logic [PIN_COUNT-1:0]   pullQ;
  logic [SYNC_STAGES-1:0] syncQ [PIN_COUNT];
  logic [PIN_COUNT-1:0]   inSync;
  logic [DATA_W-1:0]      word;

  always_ff @(posedge clk) begin
    for (int p = 0; p < PIN_COUNT; p++) begin
      if (!rstN) begin
        dirQ[p]  <= 1'b0;
        valQ[p]  <= 1'b0;
        pullQ[p] <= 1'b0;
        syncQ[p] <= '0;
      end else begin
        if (stb.setDir[p])  dirQ[p]  <= dirIn[p];
        if (stb.setVal[p])  valQ[p]  <= valIn[p];
        if (stb.setPull[p]) pullQ[p] <= pullIn[p];
        syncQ[p] <= {syncQ[p][SYNC_STAGES-2:0], padIn[p]};
      end
    end
  end

  for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
    assign inSync[p] = syncQ[p][SYNC_STAGES-1];
  end

  always_comb begin
    word = '0;
    for (int p = 0; p < PIN_COUNT; p++) begin
      word[p*FIELD_STRIDE + OFS_DIR]  = dirQ[p];
      word[p*FIELD_STRIDE + OFS_VAL]  = valQ[p];
      word[p*FIELD_STRIDE + OFS_IN]   = inSync[p];
      word[p*FIELD_STRIDE + OFS_PULL] = pullQ[p];
    end
  end

  assign rdData = stb.rdSel ? word : '0;
  assign padOe  = dirQ;
  assign padO   = valQ;
  assign pullEn = ~pullQ;
endmodule

// File: rtl/odPinPairReg.sv
module odPinPairReg
  import odpp_pkg::*;
#(
  parameter int                ADDR_W      = 8,
  parameter int                DATA_W      = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR   = 8'h10,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclOe,
  output logic              sclO,
  output logic              sclPullEn,
  output logic              sdaOe,
  output logic              sdaO,
  output logic              sdaPullEn
);
  localparam int USED_W = PIN_COUNT * FIELD_STRIDE;

  logic [PIN_COUNT-1:0] dirMask, valMask, pullMask;
  logic [PIN_COUNT-1:0] dirIn, valIn, pullIn;
  logic [PIN_COUNT-1:0] padOe, padO, pullEn;
  logic [DATA_W-1:0]    unusedWr;
  strobe_t              stb;

  for (genvar p = 0; p < PIN_COUNT; p++) begin : g_split
    assign dirMask[p]  = wrData[p*FIELD_STRIDE + OFS_DIR_MASK];
    assign valMask[p]  = wrData[p*FIELD_STRIDE + OFS_VAL_MASK];
    assign pullMask[p] = wrData[p*FIELD_STRIDE + OFS_PULL_MASK];
    assign dirIn[p]    = wrData[p*FIELD_STRIDE + OFS_DIR];
    assign valIn[p]    = wrData[p*FIELD_STRIDE + OFS_VAL];
    assign pullIn[p]   = wrData[p*FIELD_STRIDE + OFS_PULL];
  end
  assign unusedWr = wrData;

  odpp_ctrl #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) uCtrl (
    .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .dirMask(dirMask), .valMask(valMask), .pullMask(pullMask),
    .stb(stb)
  );

  odpp_datapath #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) uData (
    .clk(clk), .rstN(rstN), .stb(stb),
    .dirIn(dirIn), .valIn(valIn), .pullIn(pullIn),
    .padIn({sdaIn, sclIn}),
    .padOe(padOe), .padO(padO), .pullEn(pullEn),
    .rdData(rdData)
  );

  assign sclOe     = padOe[0];
  assign sclO      = padO[0];
  assign sclPullEn = pullEn[0];
  assign sdaOe     = padOe[1];
  assign sdaO      = padO[1];
  assign sdaPullEn = pullEn[1];
endmodule

// File: rtl/odPinPairChk.sv
module odPinPairChk #(
  parameter int                ADDR_W    = 8,
  parameter int                DATA_W    = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h10
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              rdEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic              sclIn,
  input logic              sdaIn,
  input logic              sclOe,
  input logic              sclO,
  input logic              sclPullEn,
  input logic              sdaOe,
  input logic              sdaO,
  input logic              sdaPullEn
);
  logic       hit;
  logic [1:0] liveCnt;
  logic       unusedSda;

  assign hit       = (addr == BASE_ADDR);
  assign unusedSda = sdaIn;

  always_ff @(posedge clk) begin
    if (!rstN)                liveCnt <= 2'd0;
    else if (liveCnt != 2'd3) liveCnt <= liveCnt + 2'd1;
  end

  // R1
  reset_release_chk: assert property (@(posedge clk)
    !rstN |=> (!sclOe && !sdaOe && sclPullEn && sdaPullEn));

  // R2
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && hit && !wrData[0]) |=> $stable(sclOe));

  // R4
  drive_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && hit && wrData[0] && wrData[1] && wrData[2] && !wrData[3])
      |=> (sclOe && !sclO));

  // R5
  pull_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && hit && !wrData[13]) |=> $stable(sdaPullEn));

  // R6
  mask_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |-> ((rdData & 32'h0000_2525) == 32'h0));

  // R7
  sync_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && hit && liveCnt >= 2'd2) |-> (rdData[4] == $past(sclIn, 2)));

  // R8
  foreign_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !hit) |=> $stable({sclOe, sclO, sclPullEn, sdaOe, sdaO, sdaPullEn}));
endmodule

bind odPinPairReg odPinPairChk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_ADDR(BASE_ADDR)
) uChk (.*);

// File: tb/sim_odPinPairReg.sv
`timescale 1ns/1ps
module sim_odPinPairReg;
  localparam logic [7:0] BASES [2] = '{8'h10, 8'h14};
  localparam int LIMIT = 2000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0]  addr = 8'h0;
  logic [31:0] wrData = 32'h0;
  logic [1:0]  padIn [2];
  logic [31:0] rdW [2];
  logic [1:0]  oeW [2], oW [2], puW [2];

  logic [1:0]  mDir [2], mVal [2], mPull [2], h1 [2], h2 [2];
  int nChk = 0, nFail = 0;
  bit done = 0;
  logic [31:0] lfsr = 32'hACE1_2468;

  always #2 clk = ~clk;

  odPinPairReg #(.BASE_ADDR(8'h10)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdW[0]),
    .sclIn(padIn[0][0]), .sdaIn(padIn[0][1]),
    .sclOe(oeW[0][0]), .sclO(oW[0][0]), .sclPullEn(puW[0][0]),
    .sdaOe(oeW[0][1]), .sdaO(oW[0][1]), .sdaPullEn(puW[0][1]));

  odPinPairReg #(.BASE_ADDR(8'h14)) u1 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdW[1]),
    .sclIn(padIn[1][0]), .sdaIn(padIn[1][1]),
    .sclOe(oeW[1][0]), .sclO(oW[1][0]), .sclPullEn(puW[1][0]),
    .sdaOe(oeW[1][1]), .sdaO(oW[1][1]), .sdaPullEn(puW[1][1]));

  // behavioural reference, updated on each rising edge
  always @(posedge clk) begin
    for (int i = 0; i < 2; i++) begin
      if (!rstN) begin
        mDir[i] = 2'b00; mVal[i] = 2'b00; mPull[i] = 2'b00;
        h1[i] = 2'b00; h2[i] = 2'b00;
      end else begin
        h2[i] = h1[i];
        h1[i] = padIn[i];
        if (wrEn && addr == BASES[i]) begin
          for (int p = 0; p < 2; p++) begin
            if (wrData[p*8+0]) mDir[i][p]  = wrData[p*8+1];
            if (wrData[p*8+2]) mVal[i][p]  = wrData[p*8+3];
            if (wrData[p*8+5]) mPull[i][p] = wrData[p*8+6];
          end
        end
      end
    end
  end

  function automatic logic [31:0] expRead(input int i);
    logic [31:0] w = 32'h0;
    for (int p = 0; p < 2; p++) begin
      w[p*8+1] = mDir[i][p];
      w[p*8+3] = mVal[i][p];
      w[p*8+4] = h2[i][p];
      w[p*8+6] = mPull[i][p];
    end
    return (rdEn && addr == BASES[i]) ? w : 32'h0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  task automatic cmpOutputs();
    for (int i = 0; i < 2; i++) begin
      chk("R2 oe", {30'h0, oeW[i]}, {30'h0, mDir[i]});
      chk("R3 out", {30'h0, oW[i]}, {30'h0, mVal[i]});
      chk("R5 pullEn", {30'h0, puW[i]}, {30'h0, ~mPull[i]});
    end
  endtask

  task automatic cyc(input logic we, input logic re, input logic [7:0] a,
                     input logic [31:0] d, input logic [1:0] in0, input logic [1:0] in1);
    @(negedge clk);
    cmpOutputs();
    wrEn = we; rdEn = re; addr = a; wrData = d;
    padIn[0] = in0; padIn[1] = in1;
    #1;
    for (int i = 0; i < 2; i++) chk("R7 read", rdW[i], expRead(i));
  endtask

  initial begin
    #(LIMIT * 4);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    logic [1:0] snapOe [2];
    logic [1:0] snapO [2];
    logic [1:0] snapPu [2];
    logic [7:0] pick;
    padIn[0] = 2'b00; padIn[1] = 2'b00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state at the ports and in the readback
    chk("R1 oe0", {30'h0, oeW[0]}, 32'h0);
    chk("R1 out0", {30'h0, oW[0]}, 32'h0);
    chk("R1 pull0", {30'h0, puW[0]}, 32'h3);
    chk("R1 pull1", {30'h0, puW[1]}, 32'h3);
    cyc(1'b0, 1'b1, 8'h10, 32'h0, 2'b00, 2'b00);
    chk("R1 read", rdW[0], 32'h0);

    // R4: pull clock low on copy 0
    cyc(1'b1, 1'b0, 8'h10, 32'h0000_0007, 2'b00, 2'b00);
    cyc(1'b0, 1'b0, 8'h10, 32'h0, 2'b00, 2'b00);
    chk("R4 low oe", {31'h0, oeW[0][0]}, 32'h1);
    chk("R4 low out", {31'h0, oW[0][0]}, 32'h0);

    // R2/R3: fields without write-enable are ignored
    cyc(1'b1, 1'b0, 8'h10, 32'h0000_0008, 2'b00, 2'b00);
    cyc(1'b0, 1'b0, 8'h10, 32'h0, 2'b00, 2'b00);
    chk("R2 dir held", {31'h0, oeW[0][0]}, 32'h1);
    chk("R3 val held", {31'h0, oW[0][0]}, 32'h0);

    // R4: release clock
    cyc(1'b1, 1'b0, 8'h10, 32'h0000_0001, 2'b00, 2'b00);
    cyc(1'b0, 1'b0, 8'h10, 32'h0, 2'b00, 2'b00);
    chk("R4 release", {31'h0, oeW[0][0]}, 32'h0);

    // R5: disable data pull-up, then an unrelated write keeps it
    cyc(1'b1, 1'b0, 8'h10, 32'h0000_6000, 2'b00, 2'b00);
    cyc(1'b1, 1'b0, 8'h10, 32'h0000_0300, 2'b00, 2'b00);
    cyc(1'b0, 1'b0, 8'h10, 32'h0, 2'b00, 2'b00);
    chk("R5 sticky", {31'h0, puW[0][1]}, 32'h0);

    // R6: write-enable positions read as 0 even after all-ones write
    cyc(1'b1, 1'b0, 8'h10, 32'hFFFF_FFFF, 2'b11, 2'b00);
    cyc(1'b0, 1'b1, 8'h10, 32'h0, 2'b11, 2'b00);
    chk("R6 masks", rdW[0] & 32'h0000_2525, 32'h0);

    // R8: foreign address leaves both copies alone
    snapOe = oeW; snapO = oW; snapPu = puW;
    cyc(1'b1, 1'b0, 8'h18, 32'hFFFF_FFFF, 2'b11, 2'b00);
    cyc(1'b0, 1'b0, 8'h18, 32'h0, 2'b11, 2'b00);
    for (int i = 0; i < 2; i++) begin
      chk("R8 oe", {30'h0, oeW[i]}, {30'h0, snapOe[i]});
      chk("R8 out", {30'h0, oW[i]}, {30'h0, snapO[i]});
      chk("R8 pull", {30'h0, puW[i]}, {30'h0, snapPu[i]});
    end
    // R8: write to copy 1 does not reach copy 0
    snapOe = oeW;
    cyc(1'b1, 1'b0, 8'h14, 32'h0000_0700, 2'b00, 2'b01);
    cyc(1'b0, 1'b0, 8'h14, 32'h0, 2'b00, 2'b01);
    chk("R8 copy1 low", {31'h0, oeW[1][1]}, 32'h1);
    chk("R8 copy0 kept", {30'h0, oeW[0]}, {30'h0, snapOe[0]});

    // mixed traffic with toggling pads
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      case (lfsr[3:2])
        2'd0: pick = 8'h10;
        2'd1: pick = 8'h14;
        2'd2: pick = 8'h18;
        default: pick = lfsr[0] ? 8'h10 : 8'h11;
      endcase
      cyc(lfsr[4], lfsr[5] | lfsr[6], pick,
          {lfsr[15:0], lfsr[31:16]}, lfsr[9:8], lfsr[12:11]);
    end
    cyc(1'b0, 1'b0, 8'h0, 32'h0, 2'b00, 2'b00);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule